// File: doc/BRIEF.md
# MPU Region Permission Checker

This block decides, for one memory access at a time, what a memory protection unit allows. Each request carries a 32-bit address, an access kind (load, store or instruction fetch) and a flag saying whether the requester is privileged. The block compares the address against a configurable number of protection regions. The base, size/enable and attribute words of those regions come from a region store outside the block, and the block reads them only while a request is captured. It returns read, write and execute permissions, whether the requested kind of access is granted, whether a region matched and which one, and whether the access missed altogether.

Two address windows are handled apart from the region scan. The private peripheral window, 0xE0000000 to 0xE00FFFFF, never takes part in the region lookup and always gets the default map. Everything from 0xE0000000 upward is system space, and execution is never allowed there, whatever a matching region says. When the protection unit is switched off, or when no region matches and the background map is enabled for this access, the default map applies. Otherwise an unmatched access misses. The result is registered, and a one-cycle valid strobe marks it.

Top module: `mpu_perm_check`

## Requirements
- R1: A response appears exactly one clock after a cycle with `reqValid` high: `rspValid` is high for that one cycle only, and the result outputs hold their value until the next request is captured.
- R2: With `mpuEnable` low, no region lookup is made: `rspHit` and `rspMiss` are 0 and the default map applies. The default map always grants read and write, and grants execute unless address bits 31:29 are 3'b111.
- R3: An address whose bits 31:20 equal 12'hE00 uses the default map and never reports a region hit, even with `mpuEnable` high and a region covering it.
- R4: Region i matches when bit 0 of its size word (enable) is 1 and the address agrees with its base on every bit above the lowest SIZE+1 bits, where SIZE is bits 5:1 of the size word. The lowest SIZE+1 base bits are ignored, and SIZE = 31 covers the whole address space.
- R5: When several regions match, the highest-numbered one decides the permissions, and its number is given on `rspRegion`.
- R6: The access-permission code is in bits 10:8 of the attribute word and decodes, as privileged/user: 000 none/none, 001 RW/none, 010 RW/RO, 011 RW/RW, 100 none/none, 101 RO/none, 110 and 111 RO/RO.
- R7: For a region hit, execute is granted exactly when read is granted, unless bit 12 (execute-never) of the attribute word is set. Execute-never clears only execute and leaves read and write as they are.
- R8: Any address with bits 31:29 equal to 3'b111 never gets execute permission, even from a region whose execute-never bit is 0.
- R9: With the unit enabled and no region matching, `bgEnable` high gives the default map with `rspMiss` 0. `bgEnable` low gives `rspMiss` 1 with read, write, execute and grant all 0 and `rspRegion` 0.
- R10: `rspGrant` follows the access kind on `reqType`: 2'b00 load checks read, 2'b01 store checks write, 2'b10 fetch checks execute, and 2'b11 is never granted.
- R11: After reset, every output is 0 until the first response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mpuEnable | input | 1 | Protection unit enabled |
| bgEnable | input | 1 | Default map allowed for unmatched accesses |
| reqValid | input | 1 | Access request present this cycle |
| reqAddr | input | 32 | Access address |
| reqType | input | 2 | 00 load, 01 store, 10 fetch, 11 reserved |
| reqPriv | input | 1 | 1 = privileged access, 0 = user |
| regionBase | input | NUM_REGIONS*32 | Base word of each region |
| regionSize | input | NUM_REGIONS*32 | Size/enable word of each region |
| regionAttr | input | NUM_REGIONS*32 | Attribute word of each region |
| rspValid | output | 1 | Result valid strobe |
| rspHit | output | 1 | A region matched |
| rspMiss | output | 1 | No region and no default map applied |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspExec | output | 1 | Execute permitted |
| rspGrant | output | 1 | The requested access kind is permitted |
| rspRegion | output | $clog2(NUM_REGIONS) | Number of the deciding region |

## Verification
The hardest case to reach from the ports is an address that sits in the peripheral window while an enabled, fully denying region also covers it. The stimulus sets up such a region across the top of the address space. It then probes one address just inside the window and one just past it. The first must get default-map rights with no hit. The second must hit the denying region. Overlapping regions of different sizes and a base word with stray low bits are used to separate the priority and alignment rules from plain matching.

// File: rtl/mpu_perm_pkg.sv
package mpu_perm_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_e;

  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  localparam logic [11:0] PPB_TAG  = 12'hE00;
  localparam logic [2:0]  SYS_TAG  = 3'b111;
  localparam int          AP_LSB   = 8;
  localparam int          XN_BIT   = 12;
  localparam int          SZ_LSB   = 1;
  localparam int          EN_BIT   = 0;

  // Permission code decode (R6); execute follows read before execute-never (R7)
  function automatic perm_t decodeAp(input logic [2:0] ap, input logic priv);
    perm_t p;
    p = '0;
    unique case (ap)
      3'b001: begin p.rd = priv;  p.wr = priv; end
      3'b010: begin p.rd = 1'b1;  p.wr = priv; end
      3'b011: begin p.rd = 1'b1;  p.wr = 1'b1; end
      3'b101: begin p.rd = priv;  p.wr = 1'b0; end
      3'b110,
      3'b111: begin p.rd = 1'b1;  p.wr = 1'b0; end
      default: p = '0;
    endcase
    p.ex = p.rd;
    return p;
  endfunction

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match (
  input  logic [31:0] addr,
  input  logic [31:0] baseWord,
  input  logic [4:0]  sizeCode,
  input  logic        enable,
  output logic        match
);
  logic [5:0]  shamt;
  logic [31:0] keepMask;

  always_comb begin
    shamt    = {1'b0, sizeCode} + 6'd1;
    keepMask = 32'hFFFF_FFFF << shamt;
    match    = enable && ((addr & keepMask) == (baseWord & keepMask));
  end
endmodule

// File: rtl/mpu_perm_ctrl.sv
module mpu_perm_ctrl
  import mpu_perm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctrlStrobe_t strobe,
  output logic        rspValid
);
  always_comb strobe.capture = reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_rsp_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/mpu_perm_dp.sv
module mpu_perm_dp
  import mpu_perm_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrlStrobe_t                        strobe,
  input  logic                               mpuEnable,
  input  logic                               bgEnable,
  input  logic [31:0]                        reqAddr,
  input  logic [1:0]                         reqType,
  input  logic                               reqPriv,
  input  logic [NUM_REGIONS-1:0][31:0]       regionBase,
  input  logic [NUM_REGIONS-1:0][31:0]       regionSize,
  input  logic [NUM_REGIONS-1:0][31:0]       regionAttr,
  output logic                               rspHit,
  output logic                               rspMiss,
  output logic                               rspRead,
  output logic                               rspWrite,
  output logic                               rspExec,
  output logic                               rspGrant,
  output logic [$clog2(NUM_REGIONS)-1:0]     rspRegion
);
  localparam int IDX_W = $clog2(NUM_REGIONS);

  logic [NUM_REGIONS-1:0] regionMatch;
  logic [NUM_REGIONS-1:0] unusedBits;

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : gRegion
      mpu_region_match u_match (
        .addr     (reqAddr),
        .baseWord (regionBase[g]),
        .sizeCode (regionSize[g][SZ_LSB+4:SZ_LSB]),
        .enable   (regionSize[g][EN_BIT]),
        .match    (regionMatch[g])
      );
      assign unusedBits[g] = ^{regionSize[g][31:6], regionAttr[g][31:13],
                               regionAttr[g][11], regionAttr[g][7:0]};
    end
  endgenerate

  logic             ppbWindow;
  logic             sysSpace;
  logic             anyMatch;
  logic [IDX_W-1:0] selIdx;
  perm_t            defPerm;
  perm_t            regPerm;
  perm_t            nextPerm;
  logic             nextHit;
  logic             nextMiss;
  logic             nextGrant;
  logic [IDX_W-1:0] nextRegion;

  // Priority scan: a later (higher-numbered) match overrides earlier ones (R5)
  always_comb begin
    anyMatch = 1'b0;
    selIdx   = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (regionMatch[i]) begin
        anyMatch = 1'b1;
        selIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    ppbWindow = (reqAddr[31:20] == PPB_TAG);
    sysSpace  = (reqAddr[31:29] == SYS_TAG);

    defPerm.rd = 1'b1;
    defPerm.wr = 1'b1;
    defPerm.ex = !sysSpace;

    regPerm = decodeAp(regionAttr[selIdx][AP_LSB+2:AP_LSB], reqPriv);
    if (regionAttr[selIdx][XN_BIT] || sysSpace) regPerm.ex = 1'b0;

    nextHit    = 1'b0;
    nextMiss   = 1'b0;
    nextRegion = '0;
    if (!mpuEnable || ppbWindow) begin
      nextPerm = defPerm;
    end else if (anyMatch) begin
      nextPerm   = regPerm;
      nextHit    = 1'b1;
      nextRegion = selIdx;
    end else if (bgEnable) begin
      nextPerm = defPerm;
    end else begin
      nextPerm = '0;
      nextMiss = 1'b1;
    end

    unique case (reqType)
      ACC_LOAD:  nextGrant = nextPerm.rd;
      ACC_STORE: nextGrant = nextPerm.wr;
      ACC_FETCH: nextGrant = nextPerm.ex;
      default:   nextGrant = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit    <= 1'b0;
      rspMiss   <= 1'b0;
      rspRead   <= 1'b0;
      rspWrite  <= 1'b0;
      rspExec   <= 1'b0;
      rspGrant  <= 1'b0;
      rspRegion <= '0;
    end else if (strobe.capture) begin
      rspHit    <= nextHit;
      rspMiss   <= nextMiss;
      rspRead   <= nextPerm.rd;
      rspWrite  <= nextPerm.wr;
      rspExec   <= nextPerm.ex;
      rspGrant  <= nextGrant;
      rspRegion <= nextRegion;
    end
  end

  assert_off_uses_default_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !mpuEnable |=> !rspHit && !rspMiss && rspRead && rspWrite);
  assert_ppb_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && mpuEnable && (reqAddr[31:20] == 12'hE00) |=> !rspHit && !rspMiss);
  assert_write_needs_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> rspRead);
  assert_sys_no_exec_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (reqAddr[31:29] == 3'b111) |=> !rspExec);
  assert_miss_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> !(rspRead || rspWrite || rspExec || rspGrant || rspHit));
  assert_reserved_kind_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (reqType == 2'b11) |=> !rspGrant);
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
  import mpu_perm_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               mpuEnable,
  input  logic                               bgEnable,
  input  logic                               reqValid,
  input  logic [31:0]                        reqAddr,
  input  logic [1:0]                         reqType,
  input  logic                               reqPriv,
  input  logic [NUM_REGIONS-1:0][31:0]       regionBase,
  input  logic [NUM_REGIONS-1:0][31:0]       regionSize,
  input  logic [NUM_REGIONS-1:0][31:0]       regionAttr,
  output logic                               rspValid,
  output logic                               rspHit,
  output logic                               rspMiss,
  output logic                               rspRead,
  output logic                               rspWrite,
  output logic                               rspExec,
  output logic                               rspGrant,
  output logic [$clog2(NUM_REGIONS)-1:0]     rspRegion
);
  ctrlStrobe_t strobe;

  mpu_perm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  mpu_perm_dp #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mpuEnable  (mpuEnable),
    .bgEnable   (bgEnable),
    .reqAddr    (reqAddr),
    .reqType    (reqType),
    .reqPriv    (reqPriv),
    .regionBase (regionBase),
    .regionSize (regionSize),
    .regionAttr (regionAttr),
    .rspHit     (rspHit),
    .rspMiss    (rspMiss),
    .rspRead    (rspRead),
    .rspWrite   (rspWrite),
    .rspExec    (rspExec),
    .rspGrant   (rspGrant),
    .rspRegion  (rspRegion)
  );
endmodule

// File: tb/mpu_perm_check_tb.sv
module mpu_perm_check_tb;
  localparam int N = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              mpuEnable = 1'b0;
  logic              bgEnable = 1'b0;
  logic              reqValid = 1'b0;
  logic [31:0]       reqAddr = '0;
  logic [1:0]        reqType = '0;
  logic              reqPriv = 1'b0;
  logic [N-1:0][31:0] regionBase = '0;
  logic [N-1:0][31:0] regionSize = '0;
  logic [N-1:0][31:0] regionAttr = '0;
  logic              rspValid, rspHit, rspMiss, rspRead, rspWrite, rspExec, rspGrant;
  logic [2:0]        rspRegion;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mpu_perm_check #(.NUM_REGIONS(N)) u_dut (
    .clk(clk), .rstN(rstN), .mpuEnable(mpuEnable), .bgEnable(bgEnable),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqType(reqType), .reqPriv(reqPriv),
    .regionBase(regionBase), .regionSize(regionSize), .regionAttr(regionAttr),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspRead(rspRead),
    .rspWrite(rspWrite), .rspExec(rspExec), .rspGrant(rspGrant), .rspRegion(rspRegion)
  );

  task automatic clearRegions();
    regionBase = '0;
    regionSize = '0;
    regionAttr = '0;
  endtask

  task automatic setRegion(int idx, logic [31:0] base, logic [4:0] sz, logic en,
                           logic [2:0] ap, logic xn);
    regionBase[idx] = base;
    regionSize[idx] = {26'd0, sz, en};
    regionAttr[idx] = {19'd0, xn, 1'b0, ap, 8'd0};
  endtask

  // Drives one request and returns at the negedge after the capturing edge
  task automatic access(logic [31:0] a, logic [1:0] t, logic p);
    @(negedge clk);
    reqAddr  = a;
    reqType  = t;
    reqPriv  = p;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect8(string tag, logic v, logic h, logic m, logic r, logic w,
                         logic x, logic g, logic [2:0] reg_n);
    logic [9:0] act, exp;
    act = {rspValid, rspHit, rspMiss, rspRead, rspWrite, rspExec, rspGrant, rspRegion};
    exp = {v, h, m, r, w, x, g, reg_n};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual v/h/m/r/w/x/g/reg=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    expect8("R11 reset state", 0, 0, 0, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic t_disabled();
    clearRegions();
    setRegion(0, 32'h0, 5'd31, 1'b1, 3'b000, 1'b0);
    mpuEnable = 1'b0; bgEnable = 1'b0;
    access(32'h2000_0000, 2'b01, 1'b0);
    expect8("R2 disabled store", 1, 0, 0, 1, 1, 1, 1, 3'd0);
    access(32'hF000_0000, 2'b10, 1'b1);
    expect8("R2 disabled fetch system", 1, 0, 0, 1, 1, 0, 0, 3'd0);
  endtask

  task automatic t_timing();
    clearRegions();
    setRegion(2, 32'h2000_0000, 5'd11, 1'b1, 3'b011, 1'b0);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'h2000_0010, 2'b00, 1'b1);
    expect8("R1 response strobe", 1, 1, 0, 1, 1, 1, 1, 3'd2);
    @(negedge clk);
    expect8("R1 strobe drops, result held", 0, 1, 0, 1, 1, 1, 1, 3'd2);
  endtask

  task automatic t_ppb();
    clearRegions();
    setRegion(7, 32'hE000_0000, 5'd28, 1'b1, 3'b000, 1'b0);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'hE00F_FFFC, 2'b00, 1'b0);
    expect8("R3 peripheral window bypass", 1, 0, 0, 1, 1, 0, 1, 3'd0);
    access(32'hE010_0000, 2'b00, 1'b1);
    expect8("R3 just past window hits region", 1, 1, 0, 0, 0, 0, 0, 3'd7);
  endtask

  task automatic t_match();
    clearRegions();
    setRegion(2, 32'h2000_0123, 5'd11, 1'b1, 3'b011, 1'b0);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'h2000_0000, 2'b00, 1'b1);
    expect8("R4 low base bits ignored", 1, 1, 0, 1, 1, 1, 1, 3'd2);
    access(32'h2000_0FFF, 2'b01, 1'b1);
    expect8("R4 top of region", 1, 1, 0, 1, 1, 1, 1, 3'd2);
    access(32'h2000_1000, 2'b00, 1'b1);
    expect8("R4 one past region", 1, 0, 1, 0, 0, 0, 0, 3'd0);
    access(32'h1FFF_FFFC, 2'b00, 1'b1);
    expect8("R4 below region", 1, 0, 1, 0, 0, 0, 0, 3'd0);
    setRegion(2, 32'h2000_0000, 5'd11, 1'b0, 3'b011, 1'b0);
    access(32'h2000_0000, 2'b00, 1'b1);
    expect8("R4 disabled region", 1, 0, 1, 0, 0, 0, 0, 3'd0);
    clearRegions();
    setRegion(0, 32'h1234_0000, 5'd31, 1'b1, 3'b011, 1'b0);
    access(32'h8000_0000, 2'b10, 1'b0);
    expect8("R4 full-space region", 1, 1, 0, 1, 1, 1, 1, 3'd0);
  endtask

  task automatic t_priority();
    clearRegions();
    setRegion(1, 32'h3000_0000, 5'd19, 1'b1, 3'b011, 1'b0);
    setRegion(5, 32'h3000_0000, 5'd15, 1'b1, 3'b101, 1'b0);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'h3000_0100, 2'b00, 1'b1);
    expect8("R5 higher region wins priv", 1, 1, 0, 1, 0, 1, 1, 3'd5);
    access(32'h3000_0100, 2'b00, 1'b0);
    expect8("R5 higher region wins user", 1, 1, 0, 0, 0, 0, 0, 3'd5);
    access(32'h3001_0000, 2'b01, 1'b1);
    expect8("R5 only lower region", 1, 1, 0, 1, 1, 1, 1, 3'd1);
  endtask

  function automatic logic [1:0] apTable(logic [2:0] ap, logic priv);
    case (ap)
      3'd1: return priv ? 2'b11 : 2'b00;
      3'd2: return priv ? 2'b11 : 2'b10;
      3'd3: return 2'b11;
      3'd5: return priv ? 2'b10 : 2'b00;
      3'd6, 3'd7: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic t_ap();
    logic [1:0] rw;
    clearRegions();
    mpuEnable = 1'b1; bgEnable = 1'b0;
    for (int a = 0; a < 8; a++) begin
      for (int p = 0; p < 2; p++) begin
        setRegion(3, 32'h4000_0000, 5'd15, 1'b1, 3'(a), 1'b0);
        access(32'h4000_2000, 2'b00, 1'(p));
        rw = apTable(3'(a), 1'(p));
        expect8($sformatf("R6 ap=%0d priv=%0d", a, p), 1, 1, 0, rw[1], rw[0], rw[1], rw[1], 3'd3);
      end
    end
  endtask

  task automatic t_xn();
    clearRegions();
    setRegion(4, 32'h5000_0000, 5'd11, 1'b1, 3'b011, 1'b1);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'h5000_0040, 2'b10, 1'b1);
    expect8("R7 xn blocks fetch", 1, 1, 0, 1, 1, 0, 0, 3'd4);
    access(32'h5000_0040, 2'b01, 1'b1);
    expect8("R7 xn keeps store", 1, 1, 0, 1, 1, 0, 1, 3'd4);
    setRegion(4, 32'h5000_0000, 5'd11, 1'b1, 3'b011, 1'b0);
    access(32'h5000_0040, 2'b10, 1'b1);
    expect8("R7 no xn allows fetch", 1, 1, 0, 1, 1, 1, 1, 3'd4);
  endtask

  task automatic t_sys();
    clearRegions();
    setRegion(6, 32'hF000_0000, 5'd27, 1'b1, 3'b011, 1'b0);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'hF000_0040, 2'b10, 1'b1);
    expect8("R8 system space forced xn", 1, 1, 0, 1, 1, 0, 0, 3'd6);
  endtask

  task automatic t_bg();
    clearRegions();
    mpuEnable = 1'b1; bgEnable = 1'b1;
    access(32'h6000_0000, 2'b00, 1'b1);
    expect8("R9 background default", 1, 0, 0, 1, 1, 1, 1, 3'd0);
    access(32'hF800_0000, 2'b10, 1'b1);
    expect8("R9 background system fetch", 1, 0, 0, 1, 1, 0, 0, 3'd0);
    bgEnable = 1'b0;
    access(32'h6000_0000, 2'b00, 1'b1);
    expect8("R9 no background miss", 1, 0, 1, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic t_grant();
    clearRegions();
    setRegion(0, 32'h0, 5'd31, 1'b1, 3'b011, 1'b0);
    mpuEnable = 1'b1; bgEnable = 1'b0;
    access(32'h7000_0000, 2'b11, 1'b1);
    expect8("R10 reserved kind denied", 1, 1, 0, 1, 1, 1, 0, 3'd0);
    setRegion(0, 32'h0, 5'd31, 1'b1, 3'b110, 1'b0);
    access(32'h7000_0000, 2'b01, 1'b1);
    expect8("R10 store on read-only", 1, 1, 0, 1, 0, 1, 0, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_timing();
    t_ppb();
    t_match();
    t_priority();
    t_ap();
    t_xn();
    t_sys();
    t_bg();
    t_grant();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule